// File: doc/BRIEF.md
# Framed Byte-Stream Receiver with Node Filter

This block sits behind a byte-wide serial link and recovers short addressed frames from it. Each arriving byte goes into a small ring store. A parser walks the ring looking for the sync value 0x5A and decodes two nibble-packed header bytes. It then steps over the payload and compares the trailing 16-bit check word with a CRC it computes itself. Only a frame that passes every check and is meant for this node, either by its own address or by the general-call address 0, is replayed from the ring onto the output. The output is a contiguous burst of payload bytes with first and last markers. The source, function and length fields are held steady for the whole burst, and a flag shows whether the frame was a general call.

The sync value is not reserved, so a stray 0x5A in the stream can start a false frame. When a candidate fails its header checks or its CRC, the parser rewinds and resumes the search at the byte right after the false sync. The ring still holds every byte of the candidate, so a real frame that began inside the false one is still found. If a frame stalls in mid-flight for longer than `GAP_MAX` cycles, it is flushed. A saturating counter tallies CRC failures and clears on a pulse. Bytes that arrive while the ring is full are dropped. A ring of 32 bytes leaves room for one maximum frame plus input that arrives during replay.

Top module: `pkt_rx`

## Requirements
- R1: After synchronous reset, `out_valid`, `out_sop` and `out_eop` are 0 and `err_count` is 0.
- R2: The frame layout is: the sync byte, then header byte A (destination in bits 7:4, source in bits 3:0), then header byte B (function in bits 7:4, length in bits 3:0), then the payload bytes, then the CRC with its high byte first. For an accepted frame, the payload appears in arrival order as one unbroken run of `out_valid` beats. `out_sop` is set on the first beat and `out_eop` on the last. `out_src`, `out_fxn` and `out_len` carry the header fields.
- R3: A frame whose destination equals `my_addr` is delivered with `out_bcast` = 0. A frame whose destination is 0 is delivered with `out_bcast` = 1.
- R4: A frame with a correct CRC and any other destination produces no output beat and leaves `err_count` unchanged.
- R5: The CRC uses polynomial 0x8005, starts from 0x0000 and shifts bits most significant first, without reflection. It covers the sync byte, both header bytes and the payload. On a mismatch nothing is output and `err_count` rises by one.
- R6: A frame with source 0 or length 0 is discarded with no output, and `err_count` is unchanged.
- R7: The value 0x5A inside the header, payload or CRC of a frame does not disturb its reception.
- R8: After a rejected candidate, the search for the sync byte restarts at the byte that followed the false sync. A real frame whose sync byte was swallowed by a false candidate is therefore still delivered.
- R9: Inside a frame, a wait of more than `GAP_MAX` cycles with no buffered byte discards the partial frame without touching `err_count`. A shorter wait does not disturb it.
- R10: `err_count` saturates at its all-ones value.
- R11: A one-cycle `err_clr` pulse sets `err_count` to 0 on the next cycle.
- R12: The maximum payload of 15 bytes is delivered complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_addr | input | 4 | Address of this node |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_byte | input | 8 | Received stream byte |
| err_clr | input | 1 | Pulse that zeroes the CRC error counter |
| out_valid | output | 1 | Payload beat valid |
| out_sop | output | 1 | First payload beat of a frame |
| out_eop | output | 1 | Last payload beat of a frame |
| out_data | output | 8 | Payload byte |
| out_src | output | 4 | Source address of the delivered frame |
| out_fxn | output | 4 | Function code of the delivered frame |
| out_len | output | 4 | Payload length of the delivered frame |
| out_bcast | output | 1 | Delivered frame was a general call |
| err_count | output | ERR_W | Saturating CRC failure count |

## Verification
The hardest situation to reach is the rewind case. In that case, the sync byte of a good frame has already been consumed as header data of a false candidate, and it can only be found again by going back into buffered bytes. The stimulus creates it by sending a lone 0x5A directly before a real frame. The false candidate then decodes a valid source and a long enough length to swallow the real header. It fails its CRC and must rewind onto the real sync byte. The stall timeout is reached by splitting a frame with an idle period longer than `GAP_MAX`. Saturation is reached by running the bench with a narrow counter.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam logic [7:0]  SYNC_BYTE = 8'h5A;
  localparam logic [15:0] CRC_POLY  = 16'h8005;

  typedef enum logic [2:0] {
    S_HUNT, S_HDRA, S_HDRB, S_PAY, S_CRCH, S_CRCL, S_EMIT
  } rx_state_e;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/pkt_rx_ring.sv
module pkt_rx_ring #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [AW:0]   keep_ptr,
  input  logic [AW:0]   rd_addr,
  output logic [7:0]    rd_data,
  output logic [AW:0]   wr_ptr
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]  mem [DEPTH];
  logic [AW:0] occ;
  logic        full;
  logic        do_wr;

  assign occ   = wr_ptr - keep_ptr;
  assign full  = occ[AW];
  assign do_wr = wr_en && !full;

  // storage without reset so that it maps to RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        wr_ptr <= '0;
    else if (do_wr) wr_ptr <= wr_ptr + 1'b1;
  end

  assign rd_data = mem[rd_addr[AW-1:0]];

endmodule

// File: rtl/pkt_rx_parse.sv
module pkt_rx_parse
  import pkt_rx_pkg::*;
#(
  parameter int AW      = 5,
  parameter int GAP_MAX = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    my_addr,
  input  logic [AW:0]   wr_ptr,
  input  logic [7:0]    rd_data,
  output logic [AW:0]   rd_addr,
  output logic [AW:0]   keep_ptr,
  output logic          crc_bad,
  output logic          o_valid,
  output logic          o_sop,
  output logic          o_eop,
  output logic [7:0]    o_data,
  output logic [3:0]    o_src,
  output logic [3:0]    o_fxn,
  output logic [3:0]    o_len,
  output logic          o_bcast
);
  localparam int GW = $clog2(GAP_MAX + 1);
  localparam logic [AW:0] PAY_OFS = (AW+1)'(3);

  rx_state_e   st;
  logic [AW:0] rd_ptr, sof_ptr, em_ptr;
  logic [3:0]  dst_q, src_q, fxn_q, len_q, cnt_q;
  logic [15:0] crc_q;
  logic [7:0]  crc_hi;
  logic [GW-1:0] gap_q;
  logic        avail;

  assign avail    = (rd_ptr != wr_ptr);
  assign rd_addr  = (st == S_EMIT) ? em_ptr : rd_ptr;
  assign keep_ptr = (st == S_HUNT) ? rd_ptr : sof_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_HUNT;
      rd_ptr  <= '0;
      sof_ptr <= '0;
      em_ptr  <= '0;
      dst_q   <= '0;
      src_q   <= '0;
      fxn_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      crc_q   <= '0;
      crc_hi  <= '0;
      gap_q   <= '0;
      crc_bad <= 1'b0;
      o_valid <= 1'b0;
      o_sop   <= 1'b0;
      o_eop   <= 1'b0;
      o_data  <= '0;
      o_src   <= '0;
      o_fxn   <= '0;
      o_len   <= '0;
      o_bcast <= 1'b0;
    end else begin
      crc_bad <= 1'b0;
      o_valid <= 1'b0;
      o_sop   <= 1'b0;
      o_eop   <= 1'b0;
      if (st == S_EMIT) begin
        // replay accepted payload from the ring
        o_valid <= 1'b1;
        o_data  <= rd_data;
        o_sop   <= (cnt_q == len_q);
        o_eop   <= (cnt_q == 4'd1);
        em_ptr  <= em_ptr + 1'b1;
        cnt_q   <= cnt_q - 1'b1;
        if (cnt_q == 4'd1) st <= S_HUNT;
      end else if (st != S_HUNT && !avail) begin
        // stalled mid-frame
        if (gap_q == GW'(GAP_MAX)) begin
          st     <= S_HUNT;
          rd_ptr <= wr_ptr;
          gap_q  <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end else if (avail) begin
        gap_q  <= '0;
        rd_ptr <= rd_ptr + 1'b1;
        unique case (st)
          S_HUNT: begin
            if (rd_data == SYNC_BYTE) begin
              sof_ptr <= rd_ptr;
              crc_q   <= crc16_step(16'h0000, rd_data);
              st      <= S_HDRA;
            end
          end
          S_HDRA: begin
            if (rd_data[3:0] == 4'd0) begin
              rd_ptr <= sof_ptr + 1'b1;
              st     <= S_HUNT;
            end else begin
              dst_q <= rd_data[7:4];
              src_q <= rd_data[3:0];
              crc_q <= crc16_step(crc_q, rd_data);
              st    <= S_HDRB;
            end
          end
          S_HDRB: begin
            if (rd_data[3:0] == 4'd0) begin
              rd_ptr <= sof_ptr + 1'b1;
              st     <= S_HUNT;
            end else begin
              fxn_q <= rd_data[7:4];
              len_q <= rd_data[3:0];
              cnt_q <= rd_data[3:0];
              crc_q <= crc16_step(crc_q, rd_data);
              st    <= S_PAY;
            end
          end
          S_PAY: begin
            crc_q <= crc16_step(crc_q, rd_data);
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == 4'd1) st <= S_CRCH;
          end
          S_CRCH: begin
            crc_hi <= rd_data;
            st     <= S_CRCL;
          end
          S_CRCL: begin
            if ({crc_hi, rd_data} != crc_q) begin
              crc_bad <= 1'b1;
              rd_ptr  <= sof_ptr + 1'b1;
              st      <= S_HUNT;
            end else if (dst_q == 4'd0 || dst_q == my_addr) begin
              em_ptr  <= sof_ptr + PAY_OFS;
              cnt_q   <= len_q;
              o_src   <= src_q;
              o_fxn   <= fxn_q;
              o_len   <= len_q;
              o_bcast <= (dst_q == 4'd0);
              st      <= S_EMIT;
            end else begin
              st <= S_HUNT;
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  // R2: markers only on valid beats, bursts unbroken
  a_r2_marks: assert property (@(posedge clk) disable iff (rst)
    (o_sop || o_eop) |-> o_valid);
  a_r2_burst: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_eop) |=> (o_valid && !o_sop));
  // R3: delivered frames are for this node or general call
  a_r3_filter: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_bcast || dst_q == my_addr));
  // R6: never deliver a zero source or zero length
  a_r6_hdr_ok: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_src != 4'd0 && o_len != 4'd0));

endmodule

// File: rtl/pkt_rx_errcnt.sv
module pkt_rx_errcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
  end

  // R10: stays at full scale
  a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1 && !clr) |=> cnt == '1);
  // R11: clear pulse zeroes
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
  // R5: grows by at most one per cycle
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/pkt_rx.sv
module pkt_rx #(
  parameter int AW      = 5,
  parameter int GAP_MAX = 16,
  parameter int ERR_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       my_addr,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             err_clr,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_eop,
  output logic [7:0]       out_data,
  output logic [3:0]       out_src,
  output logic [3:0]       out_fxn,
  output logic [3:0]       out_len,
  output logic             out_bcast,
  output logic [ERR_W-1:0] err_count
);
  logic [AW:0] wr_ptr, rd_addr, keep_ptr;
  logic [7:0]  rd_data;
  logic        crc_bad;

  pkt_rx_ring #(.AW(AW)) u_ring (
    .clk(clk), .rst(rst), .wr_en(in_valid), .wr_data(in_byte),
    .keep_ptr(keep_ptr), .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr)
  );

  pkt_rx_parse #(.AW(AW), .GAP_MAX(GAP_MAX)) u_parse (
    .clk(clk), .rst(rst), .my_addr(my_addr), .wr_ptr(wr_ptr), .rd_data(rd_data),
    .rd_addr(rd_addr), .keep_ptr(keep_ptr), .crc_bad(crc_bad),
    .o_valid(out_valid), .o_sop(out_sop), .o_eop(out_eop), .o_data(out_data),
    .o_src(out_src), .o_fxn(out_fxn), .o_len(out_len), .o_bcast(out_bcast)
  );

  pkt_rx_errcnt #(.W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .clr(err_clr), .inc(crc_bad), .cnt(err_count)
  );

endmodule

// File: tb/sim_pkt_rx.sv
module sim_pkt_rx;
  localparam int GAPM = 8;
  localparam int EW   = 4;
  localparam logic [3:0] ME = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic err_clr = 1'b0;
  logic out_valid, out_sop, out_eop, out_bcast;
  logic [7:0] out_data;
  logic [3:0] out_src, out_fxn, out_len;
  logic [EW-1:0] err_count;

  always #2.5 clk = ~clk;

  pkt_rx #(.AW(5), .GAP_MAX(GAPM), .ERR_W(EW)) u0 (
    .clk(clk), .rst(rst), .my_addr(ME), .in_valid(in_valid), .in_byte(in_byte),
    .err_clr(err_clr), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data), .out_src(out_src), .out_fxn(out_fxn), .out_len(out_len),
    .out_bcast(out_bcast), .err_count(err_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] pk [32];
  int pk_n;

  logic [7:0] cap_d [64];
  bit cap_s [64];
  bit cap_e [64];
  int cap_n = 0;
  int sop_n = 0;
  logic [3:0] c_src, c_fxn, c_len;
  logic c_bc;

  always @(negedge clk) begin
    if (out_valid && cap_n < 64) begin
      cap_d[cap_n] = out_data;
      cap_s[cap_n] = out_sop;
      cap_e[cap_n] = out_eop;
      cap_n = cap_n + 1;
      if (out_sop) begin
        sop_n = sop_n + 1;
        c_src = out_src; c_fxn = out_fxn; c_len = out_len; c_bc = out_bcast;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h8005;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic fix_crc();
    logic [15:0] c = 16'h0;
    int n = 3 + int'(pk[2][3:0]);
    for (int i = 0; i < n; i++) c = bcrc(c, pk[i]);
    pk[n] = c[15:8];
    pk[n+1] = c[7:0];
    pk_n = n + 2;
  endtask

  task automatic mk(input logic [3:0] dst, input logic [3:0] src, input logic [3:0] fxn,
                    input logic [3:0] len, input logic [7:0] base);
    pk[0] = 8'h5A;
    pk[1] = {dst, src};
    pk[2] = {fxn, len};
    for (int i = 0; i < int'(len); i++) pk[3+i] = base + 8'(i * 11);
    fix_crc();
  endtask

  task automatic tx(input int from, input int to, input int g);
    for (int i = from; i <= to; i++) begin
      in_valid = 1'b1; in_byte = pk[i];
      @(negedge clk);
      in_valid = 1'b0;
      repeat (g) @(negedge clk);
    end
  endtask

  task automatic tx_raw(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clr_cap();
    cap_n = 0; sop_n = 0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_frame(input string tag, input logic [3:0] src, input logic [3:0] fxn,
                              input int len, input bit bc);
    bit ok = 1;
    chk(cap_n == len, {tag, " beat count"}, cap_n, len);
    chk(sop_n == 1, {tag, " one sop"}, sop_n, 1);
    for (int i = 0; i < len && i < cap_n; i++) begin
      if (cap_d[i] != pk[3+i]) ok = 0;
      if (cap_s[i] != (i == 0)) ok = 0;
      if (cap_e[i] != (i == len - 1)) ok = 0;
    end
    chk(ok, {tag, " payload/markers"}, ok, 1);
    chk(c_src == src && c_fxn == fxn && c_len == 4'(len),
        {tag, " header fields"}, {c_src, c_fxn, c_len}, {src, fxn, 4'(len)});
    chk(c_bc == bc, {tag, " bcast"}, c_bc, bc);
  endtask

  task automatic t_reset();
    chk(!out_valid && !out_sop && !out_eop, "R1 outputs idle", out_valid, 0);
    chk(err_count == 0, "R1 counter zero", err_count, 0);
  endtask

  task automatic t_unicast();
    clr_cap();
    mk(ME, 4'h5, 4'h9, 4'd4, 8'h10);
    tx(0, pk_n - 1, 1);
    settle();
    expect_frame("R2 R3 unicast", 4'h5, 4'h9, 4, 1'b0);
  endtask

  task automatic t_bcast();
    clr_cap();
    mk(4'h0, 4'h7, 4'h2, 4'd3, 8'h21);
    tx(0, pk_n - 1, 0);
    settle();
    expect_frame("R3 general call", 4'h7, 4'h2, 3, 1'b1);
  endtask

  task automatic t_other();
    logic [EW-1:0] e0 = err_count;
    clr_cap();
    mk(4'h7, 4'h5, 4'h1, 4'd2, 8'h10);
    tx(0, pk_n - 1, 0);
    settle();
    chk(cap_n == 0, "R4 foreign frame dropped", cap_n, 0);
    chk(err_count == e0, "R4 counter unchanged", err_count, e0);
  endtask

  task automatic t_badcrc();
    logic [EW-1:0] e0 = err_count;
    clr_cap();
    mk(ME, 4'h5, 4'h1, 4'd3, 8'h10);
    pk[pk_n-1] = pk[pk_n-1] ^ 8'h01;
    tx(0, pk_n - 1, 0);
    settle();
    chk(cap_n == 0, "R5 bad crc no output", cap_n, 0);
    chk(err_count == e0 + 1'b1, "R5 counter step", err_count, e0 + 1);
  endtask

  task automatic t_badhdr();
    logic [EW-1:0] e0 = err_count;
    clr_cap();
    mk(ME, 4'h0, 4'h1, 4'd2, 8'h10);
    tx(0, pk_n - 1, 0);
    settle();
    chk(cap_n == 0, "R6 zero source dropped", cap_n, 0);
    mk(ME, 4'h4, 4'h1, 4'd0, 8'h10);
    tx(0, pk_n - 1, 0);
    settle();
    chk(cap_n == 0, "R6 zero length dropped", cap_n, 0);
    chk(err_count == e0, "R6 counter unchanged", err_count, e0);
  endtask

  task automatic t_embed();
    clr_cap();
    mk(ME, 4'hA, 4'h5, 4'd5, 8'h10);
    pk[4] = 8'h5A;
    pk[6] = 8'h5A;
    fix_crc();
    tx(0, pk_n - 1, 0);
    settle();
    expect_frame("R7 embedded sync", 4'hA, 4'h5, 5, 1'b0);
  endtask

  task automatic t_resync();
    logic [EW-1:0] e0 = err_count;
    clr_cap();
    mk(ME, 4'h5, 4'h6, 4'd8, 8'h10);
    tx_raw(8'h5A);
    tx(0, pk_n - 1, 0);
    settle();
    expect_frame("R8 rewind after false sync", 4'h5, 4'h6, 8, 1'b0);
    chk(err_count == e0 + 1'b1, "R8 false candidate counted", err_count, e0 + 1);
  endtask

  task automatic t_gap();
    logic [EW-1:0] e0 = err_count;
    clr_cap();
    mk(ME, 4'h2, 4'h3, 4'd4, 8'h10);
    tx(0, 4, 0);
    repeat (GAPM + 6) @(negedge clk);
    tx(5, pk_n - 1, 0);
    settle();
    chk(cap_n == 0, "R9 long stall discards", cap_n, 0);
    chk(err_count == e0, "R9 counter unchanged", err_count, e0);
    clr_cap();
    tx(0, 4, 0);
    repeat (GAPM - 3) @(negedge clk);
    tx(5, pk_n - 1, 0);
    settle();
    expect_frame("R9 short stall tolerated", 4'h2, 4'h3, 4, 1'b0);
  endtask

  task automatic t_maxlen();
    clr_cap();
    mk(4'h0, 4'hF, 4'hE, 4'd15, 8'h10);
    tx(0, pk_n - 1, 0);
    settle();
    expect_frame("R12 fifteen bytes", 4'hF, 4'hE, 15, 1'b1);
  endtask

  task automatic t_sat_clear();
    mk(ME, 4'h5, 4'h1, 4'd2, 8'h10);
    pk[pk_n-2] = pk[pk_n-2] ^ 8'h80;
    for (int k = 0; k < 20; k++) begin
      tx(0, pk_n - 1, 0);
      repeat (30) @(negedge clk);
    end
    chk(err_count == '1, "R10 counter saturates", err_count, 15);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_count == 0, "R11 clear pulse", err_count, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_bcast();
    t_other();
    t_badcrc();
    t_badhdr();
    t_embed();
    t_resync();
    t_gap();
    t_maxlen();
    t_sat_clear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule